// File: doc/BRIEF.md
# Burst-Mode Oversampled Phase Picker

This block recovers serial data at the start of every upstream burst. The burst is frequency-locked to the local bit clock but arrives with an unknown phase. Once per bit-clock cycle the block receives a vector of `NPH` samples of the line, taken at evenly spaced fractions of a bit. It also receives a burst reset line, and a falling edge on that line starts a new acquisition.

After the falling edge the block waits a fixed number of initialisation cycles. It then counts, over a window of alternating preamble bits, how often each pair of adjacent sample phases disagrees. The pair with the most disagreements marks the bit edge. The phase half a bit away from that edge is chosen as the data phase and held for the rest of the burst. The chosen phase's samples pass through a short pipeline to the data output. A lock flag rises when the first valid bit reaches the output. The output is held low from the burst reset until lock, and lock stays high until the next burst reset. If the window shows no transitions at all, lock never rises for that burst.

Top module: `bmp_phase_picker`

## Requirements
- R1: After the system reset `rst_n` is released, and with no falling edge on `burst_rst`, `lock` and `dout` are 0.
- R2: Only a 1-to-0 change of `burst_rst`, seen at a clock edge, starts an acquisition. A rising edge or a steady level has no effect on `lock`, `dout` or `phase_sel`.
- R3: Number the clock edge that sees the falling edge as edge 0, and the vector present before edge k as bit k. Bits 0 to `INIT_CYC` (0..5) have no effect on the phase choice.
- R4: Transitions are counted over bits `INIT_CYC+1` to `INIT_CYC+MEAS_BITS` (6..13). Boundary b (0..6) counts when `samp[b] != samp[b+1]` within the bit. Boundary 7 counts when `samp[7]` of the previous bit differs from `samp[0]` of the current bit.
- R5: The edge is the boundary with the highest count, and the lowest index wins a tie. `phase_sel` = (edge + NPH/2) mod NPH, and it reads 0 from edge 0 until the choice is made.
- R6: With a phase chosen, `lock` is 1 after edge 17 (first run bit 15 plus `PIPE_LAT`-1). After edge k (k >= 17), `dout` equals bit `samp[phase_sel]` of bit k-2.
- R7: `dout` and `lock` are 0 after edge 0 and stay 0 until lock.
- R8: Once high, `lock` stays high, and `phase_sel` stays fixed, until the next falling edge of `burst_rst`.
- R9: If every boundary count is zero at the end of the window, `lock` and `dout` stay 0 until the next falling edge.
- R10: A falling edge during initialisation, measurement or lock abandons the current burst and restarts acquisition from edge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, runs continuously |
| rst_n | input | 1 | Asynchronous system reset, active low |
| burst_rst | input | 1 | Burst reset; its falling edge starts acquisition |
| samp | input | NPH | One bit period of line samples, index = phase |
| dout | output | 1 | Recovered data, low until lock |
| lock | output | 1 | Phase acquired and data valid |
| phase_sel | output | clog2(NPH) | Chosen sample phase |

## Verification
The bench uses the default parameters: eight phases, five initialisation cycles, an eight-bit window and a three-stage output pipeline. With these values the whole burst timeline, from edge 0 through lock at edge 17, fits in a 40-bit burst. Every boundary, including the wrap from phase 7 to phase 0, can be reached by a chosen edge offset, and a two-edge tie can be built from just eight preamble bits. Random bursts with jittered edge offsets, flat windows, aborted bursts and rising edges on the reset line are mixed with directed cases.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_MEAS,
    ST_PICK,
    ST_RUN,
    ST_DEAD
  } bmp_state_e;
endpackage

// File: rtl/bmp_seq.sv
module bmp_seq
  import bmp_pkg::*;
#(
  parameter int INIT_CYC  = 5,
  parameter int MEAS_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_rst,
  input  logic has_edge,
  output logic burst_start,
  output logic meas_en,
  output logic pick_en,
  output logic run
);
  localparam int LIM = (INIT_CYC > MEAS_BITS) ? INIT_CYC : MEAS_BITS;
  localparam int TW  = $clog2(LIM + 1);

  bmp_state_e     st;
  logic [TW-1:0]  tcnt;
  logic           brst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brst_q <= 1'b0;
    else        brst_q <= burst_rst;
  end

  assign burst_start = brst_q & ~burst_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      tcnt <= '0;
    end else if (burst_start) begin
      st   <= ST_INIT;
      tcnt <= '0;
    end else begin
      case (st)
        ST_INIT: begin
          if (tcnt == TW'(INIT_CYC - 1)) begin
            st   <= ST_MEAS;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_MEAS: begin
          if (tcnt == TW'(MEAS_BITS - 1)) begin
            st   <= ST_PICK;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_PICK: st <= has_edge ? ST_RUN : ST_DEAD;
        default: st <= st;
      endcase
    end
  end

  assign meas_en = (st == ST_MEAS);
  assign pick_en = (st == ST_PICK);
  assign run     = (st == ST_RUN);

  a_r10_start_enters_init: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (st == ST_INIT));
  a_r9_dead_is_final: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEAD) && !burst_start |=> (st == ST_DEAD));
  a_r8_run_is_final: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) && !burst_start |=> (st == ST_RUN));
  a_r3_no_count_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INIT) |-> !meas_en);
endmodule

// File: rtl/bmp_edge_count.sv
module bmp_edge_count #(
  parameter int NPH       = 8,
  parameter int MEAS_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     meas_en,
  input  logic [NPH-1:0]           samp,
  output logic [$clog2(NPH)-1:0]   edge_idx,
  output logic                     has_edge
);
  localparam int PW = $clog2(NPH);
  localparam int CW = $clog2(MEAS_BITS + 1);

  logic [NPH-1:0][CW-1:0] cnt;
  logic [NPH-1:0]         trans;
  logic                   prev_last;

  function automatic logic [PW-1:0] first_max(input logic [NPH-1:0][CW-1:0] c);
    logic [CW-1:0] best;
    logic [PW-1:0] idx;
    best = c[0];
    idx  = '0;
    for (int i = 1; i < NPH; i++) begin
      if (c[i] > best) begin
        best = c[i];
        idx  = PW'(i);
      end
    end
    return idx;
  endfunction

  for (genvar k = 0; k < NPH - 1; k++) begin : g_inner
    assign trans[k] = samp[k] ^ samp[k+1];
  end
  assign trans[NPH-1] = prev_last ^ samp[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      prev_last <= 1'b0;
    end else begin
      prev_last <= samp[NPH-1];
      if (clr) begin
        cnt <= '0;
      end else if (meas_en) begin
        for (int k = 0; k < NPH; k++)
          cnt[k] <= cnt[k] + {{(CW-1){1'b0}}, trans[k]};
      end
    end
  end

  assign edge_idx = first_max(cnt);
  assign has_edge = |cnt;

  for (genvar k = 0; k < NPH; k++) begin : g_chk
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[k] <= CW'(MEAS_BITS));
    a_r3_hold_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_en && !clr |=> $stable(cnt[k]));
  end
endmodule

// File: rtl/bmp_steer.sv
module bmp_steer #(
  parameter int NPH      = 8,
  parameter int PIPE_LAT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   pick_en,
  input  logic                   has_edge,
  input  logic                   run,
  input  logic [$clog2(NPH)-1:0] edge_idx,
  input  logic [NPH-1:0]         samp,
  output logic                   dout,
  output logic                   lock,
  output logic [$clog2(NPH)-1:0] sel
);
  localparam int PW = $clog2(NPH);

  logic [PIPE_LAT-1:0] dpipe;
  logic [PIPE_LAT-1:0] vpipe;

  function automatic logic [PW-1:0] centre_of(input logic [PW-1:0] e);
    return e + PW'(NPH / 2);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sel <= '0;
    else if (clr)                sel <= '0;
    else if (pick_en && has_edge) sel <= centre_of(edge_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpipe <= '0;
      vpipe <= '0;
    end else if (clr) begin
      dpipe <= '0;
      vpipe <= '0;
    end else begin
      dpipe[0] <= samp[sel];
      vpipe[0] <= run;
      for (int i = 1; i < PIPE_LAT; i++) begin
        dpipe[i] <= dpipe[i-1];
        vpipe[i] <= vpipe[i-1];
      end
    end
  end

  assign lock = vpipe[PIPE_LAT-1];
  assign dout = dpipe[PIPE_LAT-1] & vpipe[PIPE_LAT-1];

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !clr |=> lock);
  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !clr |=> $stable(sel));
  a_r7_quiet_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lock && !dout);
  a_r6_lock_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> run);
  a_r9_no_pick_no_sel_change: assert property (@(posedge clk) disable iff (!rst_n)
    pick_en && !has_edge && !clr |=> $stable(sel));
endmodule

// File: rtl/bmp_phase_picker.sv
module bmp_phase_picker #(
  parameter int NPH       = 8,
  parameter int INIT_CYC  = 5,
  parameter int MEAS_BITS = 8,
  parameter int PIPE_LAT  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   burst_rst,
  input  logic [NPH-1:0]         samp,
  output logic                   dout,
  output logic                   lock,
  output logic [$clog2(NPH)-1:0] phase_sel
);
  localparam int PW = $clog2(NPH);

  logic          burst_start;
  logic          meas_en;
  logic          pick_en;
  logic          run;
  logic          has_edge;
  logic [PW-1:0] edge_idx;

  bmp_seq #(.INIT_CYC(INIT_CYC), .MEAS_BITS(MEAS_BITS)) i_seq (
    .clk(clk), .rst_n(rst_n), .burst_rst(burst_rst), .has_edge(has_edge),
    .burst_start(burst_start), .meas_en(meas_en), .pick_en(pick_en), .run(run)
  );

  bmp_edge_count #(.NPH(NPH), .MEAS_BITS(MEAS_BITS)) i_count (
    .clk(clk), .rst_n(rst_n), .clr(burst_start), .meas_en(meas_en),
    .samp(samp), .edge_idx(edge_idx), .has_edge(has_edge)
  );

  bmp_steer #(.NPH(NPH), .PIPE_LAT(PIPE_LAT)) i_steer (
    .clk(clk), .rst_n(rst_n), .clr(burst_start), .pick_en(pick_en),
    .has_edge(has_edge), .run(run), .edge_idx(edge_idx), .samp(samp),
    .dout(dout), .lock(lock), .sel(phase_sel)
  );

  a_r2_lock_ignores_rise: assert property (@(posedge clk) disable iff (!rst_n)
    lock && burst_rst |=> lock);
endmodule

// File: tb/test_bmp_phase_picker.sv
module test_bmp_phase_picker;
  localparam int PERIOD  = 10;
  localparam int LOCK_AT = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_rst = 1'b1;
  logic [7:0] samp = '0;
  logic       dout, lock;
  logic [2:0] phase_sel;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [7:0] vec [0:63];

  bmp_phase_picker i_bmp_phase_picker (
    .clk(clk), .rst_n(rst_n), .burst_rst(burst_rst), .samp(samp),
    .dout(dout), .lock(lock), .phase_sel(phase_sel)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mkvec(input bit prev, input bit cur, input int p);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (i <= p) ? prev : cur;
    return v;
  endfunction

  // mode 0 preamble, 1 flat window, 2 two-edge tie
  task automatic run_burst(input int p, input bit jit, input int len, input int rise_at,
                           input string tag, input int mode);
    bit prevbit = 0;
    int cnt [8];
    int best, edge_b, sel;
    bit has;
    for (int n = 0; n < len; n++) begin
      bit cur;
      int pn;
      cur = (n <= 16) ? ((n % 2) == 0) : 1'($urandom % 2);
      pn = p;
      if (n < 6) pn = (p + 3) % 8;
      else if (mode == 2 && n < 14) pn = (n % 2) ? p : (p + 3) % 8;
      else if (jit && ($urandom % 4) == 0) pn = (p + (($urandom % 2) ? 1 : 7)) % 8;
      vec[n] = mkvec(prevbit, cur, pn);
      if (mode == 1 && n >= 5) vec[n] = 8'hFF;
      prevbit = cur;
    end
    for (int b = 0; b < 8; b++) cnt[b] = 0;
    for (int n = 6; n <= 13; n++) begin
      for (int b = 0; b < 7; b++) cnt[b] += int'(vec[n][b] ^ vec[n][b+1]);
      cnt[7] += int'(vec[n-1][7] ^ vec[n][0]);
    end
    best = -1; edge_b = 0;
    for (int b = 7; b >= 0; b--) if (cnt[b] >= best) begin best = cnt[b]; edge_b = b; end
    has = (best > 0);
    sel = (edge_b + 4) % 8;
    for (int k = 0; k < len; k++) begin
      bit el;
      int ed;
      string t;
      burst_rst = (k == 0) ? 1'b0 : ((rise_at > 0 && k >= rise_at) ? 1'b1 : 1'b0);
      samp = vec[k];
      @(negedge clk);
      el = has && (k >= LOCK_AT);
      ed = el ? int'(vec[k-2][sel]) : 0;
      if (rise_at > 0 && k >= rise_at) t = "R2";
      else if (k < LOCK_AT) t = "R7";
      else if (has) t = "R6";
      else t = "R9";
      chk({t, " lock"}, int'(lock), int'(el));
      chk({t, " dout"}, int'(dout), ed);
      if (k == 0) chk("R5 phase_sel cleared", int'(phase_sel), 0);
      if (el) chk({tag, " phase_sel"}, int'(phase_sel), sel);
    end
  endtask

  task automatic gap(input int n, input bit exp_lock, input string tag);
    for (int i = 0; i < n; i++) begin
      burst_rst = 1'b1;
      samp = 8'($urandom);
      @(negedge clk);
      chk({tag, " lock across gap"}, int'(lock), int'(exp_lock));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      samp = 8'($urandom);
      @(negedge clk);
      chk("R1 lock after reset", int'(lock), 0);
      chk("R1 dout after reset", int'(dout), 0);
    end
    run_burst(7, 0, 40, 0, "R4 wrap boundary", 0);
    gap(2, 1, "R8");
    run_burst(2, 0, 40, 0, "R5 tie", 2);
    gap(1, 1, "R8");
    run_burst(0, 0, 35, 0, "R9", 1);
    gap(1, 0, "R9");
    run_burst(4, 0, 12, 0, "R10", 0);
    gap(1, 0, "R10");
    run_burst(1, 0, 40, 25, "R2", 0);
    gap(1, 1, "R2");
    run_burst(0, 0, 40, 0, "R3 init ignored", 0);
    gap(1, 1, "R8");
    for (int b = 0; b < 16; b++) begin
      run_burst(int'($urandom % 8), 1, 40, 0, "R5", 0);
      gap(1, 1, "R8");
    end
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule